// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration reads and writes for one PCI function that uses the type-0 header. Requests arrive on a simple single-beat port: valid, write enable, address, byte count, write data. Each request gets a response a fixed number of cycles later, carrying read data and an error flag. Only the low address byte selects a register. Upper address bits are ignored.

The block holds the writable header fields and six base address registers. Each BAR has a fixed window size and type set by parameters. The block also holds the expansion ROM register. BAR writes follow the usual sizing handshake. Writing all ones returns the size mask. Writing an address publishes a decoded base, which is the programmed bits plus an I/O or memory window offset chosen by the BAR type. It also publishes a per-BAR enable and a one-cycle pulse that reports a changed address window.

Top module: `cfg_space_resp`

## Requirements
- R1: Legal byte counts are 1, 2 and 4 on `req_size`. Any other count (0, 3, 5, 6, 7) gives an error response with no state change.
- R2: The register offset is `req_addr[7:0]`. Any offset of 0x40 or above gives an error response.
- R3: A read of N bytes at offset o returns header bytes o..o+N-1 little-endian in `rsp_rdata[8N-1:0]`, with upper bits zero. The fixed bytes are: vendor ID at 0x00, device ID at 0x02, revision at 0x08, class at 0x09, header type 0 at 0x0E, subsystem vendor at 0x2C, subsystem ID at 0x2E, interrupt pin at 0x3D, minimum grant at 0x3E, maximum latency at 0x3F.
- R4: On a one-byte write, offsets 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer) are stored. Offsets 0x08 to 0x0B and 0x3D to 0x3F complete without error and are left unchanged. Every other one-byte write offset is an error.
- R5: On a two-byte write, offsets 0x04 (command), 0x06 (status) and 0x0C are stored. Every other two-byte write offset is an error.
- R6: A write updates only the register at its offset. A two-byte write at 0x0C changes the cache line size and leaves the latency timer unchanged.
- R7: BAR n sits at offset 0x10+4n. Its bit 0 reads 1 for an I/O BAR and 0 for a memory BAR. The low type bits (2 for I/O, 4 for memory) never change.
- R8: A four-byte write of 0xFFFFFFFF to a BAR makes it read back as the inverted value of (size-1), with the type bits restored. This write does not change the decoded base.
- R9: Any other four-byte BAR write stores the bits above the type bits. If those bits are nonzero, `bar_base[n]` becomes those bits plus the I/O or memory window offset, and `range_change` pulses for one cycle. If they are zero, the decoded base stays unchanged and there is no pulse.
- R10: `bar_en[n]` is high exactly when `bar_base[n]` is nonzero. All bases are zero after reset.
- R11: A four-byte write of 0xFFFFFFFE to 0x30 makes the ROM register read back 0xFFFFFFFF. Any other value written there reads back unchanged.
- R12: A four-byte write at 0x04 stores the command and leaves the status unchanged. A four-byte write at any offset other than a BAR, 0x30 or 0x04 completes without error and has no effect.
- R13: Every response arrives exactly LATENCY rising edges after its request is sampled. Writes and errors return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 8 bits select the register |
| req_size | input | 3 | Byte count of the access |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data, right-aligned |
| bar_base | output | 6*32 | Decoded base per BAR, BAR n in bits [32n+31:32n] |
| bar_en | output | 6 | Decoded window active per BAR |
| range_change | output | 1 | One-cycle pulse on a published window change |

## Verification
The bench sweeps all 64 offsets for one- and two-byte writes against its own classification table. A decoder that swapped the silent and error lists would show up as a wrong error flag. It sizes each of the six BARs of both types and compares the result with a mask computed in the bench. A design that clobbered the type bits, or used the wrong mask width for I/O, would read back a wrong low nibble. It also programs addresses with junk in the type bits, writes addresses whose upper bits are zero, and resizes BARs after programming. These cases catch a spurious change pulse or a moved base. Further checks target the two-byte write at 0x0C, which must not spill into the latency timer, the four-byte command write, which must not touch status, and the ROM all-ones special case.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int NBAR = 6;
  localparam int HDR_BYTES = 64;
  localparam logic [7:0] OFF_BAR0 = 8'h10;
  localparam logic [7:0] OFF_ROM = 8'h30;
  localparam logic [7:0] OFF_CMD = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h06;
  localparam logic [7:0] OFF_CLS = 8'h0C;
  localparam logic [7:0] OFF_LTMR = 8'h0D;
  localparam logic [7:0] OFF_ILINE = 8'h3C;

  // read-only low type bits of a BAR
  function automatic logic [31:0] type_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  // value a BAR holds after the all-ones sizing write
  function automatic logic [31:0] sized_val(input logic [31:0] size,
                                            input logic [31:0] mask,
                                            input logic [31:0] cur);
    return (~(size - 32'd1) & ~mask) | (cur & mask);
  endfunction

  // decoded window base for programmed address bits
  function automatic logic [31:0] window_base(input logic [31:0] addr_bits,
                                              input logic [31:0] win);
    return addr_bits + win;
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/cfg_access_dec.sv
module cfg_access_dec
  import cfg_space_pkg::*;
#(
  parameter logic [7:0] DEV_BASE = 8'h40
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [7:0]      offset,
  input  logic [2:0]      size,
  output logic            acc_err,
  output logic            wr_cmd,
  output logic            wr_stat,
  output logic            wr_cls,
  output logic            wr_ltmr,
  output logic            wr_iline,
  output logic            wr_rom,
  output logic [NBAR-1:0] wr_bar
);
  logic base_err;
  logic w1_store, w1_quiet, w2_store;
  logic is_bar_off;
  logic [7:0] bar_rel;

  assign base_err = !size_legal(size) || (offset >= DEV_BASE);
  assign bar_rel = offset - OFF_BAR0;
  assign is_bar_off = (offset >= OFF_BAR0) && (bar_rel[1:0] == 2'b00) &&
                      (bar_rel[7:2] < 6'(NBAR));

  always_comb begin
    w1_store = (offset == OFF_ILINE) || (offset == OFF_CLS) || (offset == OFF_LTMR);
    w1_quiet = (offset >= 8'h08 && offset <= 8'h0B) ||
               (offset >= 8'h3D && offset <= 8'h3F);
    w2_store = (offset == OFF_CMD) || (offset == OFF_STAT) || (offset == OFF_CLS);
  end

  always_comb begin
    acc_err = 1'b0;
    wr_cmd = 1'b0; wr_stat = 1'b0; wr_cls = 1'b0; wr_ltmr = 1'b0;
    wr_iline = 1'b0; wr_rom = 1'b0; wr_bar = '0;
    if (req_valid) begin
      if (base_err) begin
        acc_err = 1'b1;
      end else if (req_write) begin
        unique case (size)
          3'd1: begin
            acc_err  = !(w1_store || w1_quiet);
            wr_iline = offset == OFF_ILINE;
            wr_cls   = offset == OFF_CLS;
            wr_ltmr  = offset == OFF_LTMR;
          end
          3'd2: begin
            acc_err = !w2_store;
            wr_cmd  = offset == OFF_CMD;
            wr_stat = offset == OFF_STAT;
            wr_cls  = offset == OFF_CLS;
          end
          default: begin
            wr_cmd = offset == OFF_CMD;
            wr_rom = offset == OFF_ROM;
            for (int i = 0; i < NBAR; i++)
              wr_bar[i] = is_bar_off && (bar_rel[7:2] == 6'(i));
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
  import cfg_space_pkg::*;
#(
  parameter logic [31:0] SIZE = 32'h100,
  parameter logic        IS_IO = 1'b0,
  parameter logic [31:0] WIN = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic [31:0] base_q,
  output logic        chg_q
);
  localparam logic [31:0] MASK = type_mask(IS_IO);
  localparam logic [31:0] RST_VAL = {31'd0, IS_IO};

  logic sizing, addr_nz, publish;
  logic [31:0] addr_bits;

  assign sizing = wr && (wdata == 32'hFFFF_FFFF);
  assign addr_bits = wdata & ~MASK;
  assign addr_nz = addr_bits != 32'd0;
  assign publish = wr && !sizing && addr_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q <= RST_VAL;
      base_q <= 32'd0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= publish;
      if (sizing)
        bar_q <= sized_val(SIZE, MASK, bar_q);
      else if (wr)
        bar_q <= addr_bits | (bar_q & MASK);
      if (publish)
        base_q <= window_base(addr_bits, WIN);
    end
  end

  assert_type_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_q & MASK) == RST_VAL);
  assert_base_moves_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q != $past(base_q)) |-> chg_q);
endmodule

// File: rtl/cfg_rsp_pipe.sv
module cfg_rsp_pipe #(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_err,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic        out_err,
  output logic [31:0] out_data
);
  localparam int N = (LATENCY < 1) ? 1 : LATENCY;
  logic [N-1:0] v_q, e_q;
  logic [31:0]  d_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0; e_q[0] <= 1'b0; d_q[0] <= '0;
    end else begin
      v_q[0] <= in_valid; e_q[0] <= in_err; d_q[0] <= in_data;
    end
  end

  for (genvar s = 1; s < N; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0; e_q[s] <= 1'b0; d_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1]; e_q[s] <= e_q[s-1]; d_q[s] <= d_q[s-1];
      end
    end
  end

  assign out_valid = v_q[N-1];
  assign out_err = v_q[N-1] & e_q[N-1];
  assign out_data = d_q[N-1];
endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfg_space_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LATENCY = 2,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h0B17,
  parameter logic [7:0]  REV_ID = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [15:0] SUB_VENDOR = 16'h5A11,
  parameter logic [15:0] SUB_ID = 16'h0042,
  parameter logic [7:0]  INT_PIN = 8'h01,
  parameter logic [7:0]  MIN_GNT = 8'h02,
  parameter logic [7:0]  MAX_LAT = 8'h04,
  parameter logic [15:0] STATUS_RST = 16'h0210,
  parameter logic [NBAR*32-1:0] BAR_SIZES = {32'h10, 32'h1000, 32'h100,
                                             32'h20000, 32'h8, 32'h400},
  parameter logic [NBAR-1:0] BAR_IO = 6'b100010,
  parameter logic [31:0] IO_WIN = 32'h0001_0000,
  parameter logic [31:0] MEM_WIN = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [NBAR*32-1:0] bar_base,
  output logic [NBAR-1:0]   bar_en,
  output logic              range_change
);
  logic [7:0] offset;
  logic dec_err, wr_cmd, wr_stat, wr_cls, wr_ltmr, wr_iline, wr_rom;
  logic [NBAR-1:0] wr_bar, bar_chg;
  logic [31:0] bar_val [NBAR];
  logic [15:0] cmd_q, stat_q;
  logic [7:0] cls_q, ltmr_q, iline_q;
  logic [31:0] rom_q;
  logic [7:0] img [HDR_BYTES];
  logic [31:0] rd_data, pipe_data;

  assign offset = req_addr[7:0];

  cfg_access_dec i_dec (
    .req_valid(req_valid), .req_write(req_write), .offset(offset),
    .size(req_size), .acc_err(dec_err), .wr_cmd(wr_cmd), .wr_stat(wr_stat),
    .wr_cls(wr_cls), .wr_ltmr(wr_ltmr), .wr_iline(wr_iline),
    .wr_rom(wr_rom), .wr_bar(wr_bar)
  );

  for (genvar b = 0; b < NBAR; b++) begin : g_bar
    cfg_bar_reg #(
      .SIZE(BAR_SIZES[b*32 +: 32]),
      .IS_IO(BAR_IO[b]),
      .WIN(BAR_IO[b] ? IO_WIN : MEM_WIN)
    ) i_bar (
      .clk(clk), .rst_n(rst_n), .wr(wr_bar[b]), .wdata(req_wdata),
      .bar_q(bar_val[b]), .base_q(bar_base[b*32 +: 32]), .chg_q(bar_chg[b])
    );
    assign bar_en[b] = bar_base[b*32 +: 32] != 32'd0;
  end

  assign range_change = |bar_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; stat_q <= STATUS_RST; cls_q <= '0; ltmr_q <= '0;
      iline_q <= '0; rom_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= req_wdata[15:0];
      if (wr_stat) stat_q <= req_wdata[15:0];
      if (wr_cls) cls_q <= req_wdata[7:0];
      if (wr_ltmr) ltmr_q <= req_wdata[7:0];
      if (wr_iline) iline_q <= req_wdata[7:0];
      if (wr_rom) rom_q <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) img[i] = 8'h00;
    {img[1], img[0]} = VENDOR_ID;
    {img[3], img[2]} = DEVICE_ID;
    {img[5], img[4]} = cmd_q;
    {img[7], img[6]} = stat_q;
    img[8] = REV_ID;
    {img[11], img[10], img[9]} = CLASS_CODE;
    img[12] = cls_q;
    img[13] = ltmr_q;
    for (int b = 0; b < NBAR; b++)
      for (int k = 0; k < 4; k++)
        img[16 + 4*b + k] = bar_val[b][8*k +: 8];
    {img[45], img[44]} = SUB_VENDOR;
    {img[47], img[46]} = SUB_ID;
    {img[51], img[50], img[49], img[48]} = rom_q;
    img[60] = iline_q;
    img[61] = INT_PIN;
    img[62] = MIN_GNT;
    img[63] = MAX_LAT;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++) begin
      if ((i < int'(req_size)) && (int'(offset) + i < HDR_BYTES))
        rd_data[8*i +: 8] = img[(int'(offset) + i) % HDR_BYTES];
    end
  end

  assign pipe_data = (req_write || dec_err) ? 32'd0 : rd_data;

  cfg_rsp_pipe #(.LATENCY(LATENCY)) i_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_err(dec_err),
    .in_data(pipe_data), .out_valid(rsp_valid), .out_err(rsp_err),
    .out_data(rsp_rdata)
  );

  assert_bad_size_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_legal(req_size)) |-> dec_err);
  assert_devspec_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && offset >= 8'h40) |-> dec_err);
  assert_rom_allones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 3'd4 && offset == OFF_ROM &&
     req_wdata == 32'hFFFF_FFFE) |=> rom_q == 32'hFFFF_FFFF);
  assert_status_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 3'd4 && offset == OFF_CMD) |=> $stable(stat_q));
  assert_err_zero_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == 32'd0);
  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (range_change && !(|wr_bar)) |=> !range_change);
endmodule

// File: tb/test_cfg_space_resp.sv
module test_cfg_space_resp;
  localparam int LAT = 2;
  localparam logic [31:0] SZ [6] = '{32'h400, 32'h8, 32'h20000, 32'h100, 32'h1000, 32'h10};
  localparam logic [5:0] IOB = 6'b100010;
  localparam logic [31:0] IOW = 32'h0001_0000;
  localparam logic [31:0] MEMW = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err, range_change;
  logic [31:0] rsp_rdata;
  logic [191:0] bar_base;
  logic [5:0] bar_en;
  int n_chk = 0, n_fail = 0;
  logic [31:0] r_data;
  logic r_err, r_rc;

  always #4 clk = ~clk;

  cfg_space_resp i_cfg_space_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bar_base(bar_base), .bar_en(bar_en), .range_change(range_change)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xact(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                      input logic [31:0] wd);
    int n;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    n = 1;
    r_rc = range_change;
    while (!rsp_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    r_data = rsp_rdata; r_err = rsp_err;
    chk(n == LAT, "R13 latency", 32'(n), 32'(LAT));
  endtask

  function automatic logic [31:0] tmask(input int b);
    return IOB[b] ? 32'h3 : 32'hF;
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R13 actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bar_en == 6'd0 && bar_base == '0, "R10 reset", {26'd0, bar_en}, 32'd0);
    // R3 reads of fixed fields
    xact(0, 12'h000, 4, 0); chk(r_data == 32'h0B17_A5C3 && !r_err, "R3 ids", r_data, 32'h0B17_A5C3);
    xact(0, 12'h008, 4, 0); chk(r_data == 32'h0200_0003, "R3 rev/class", r_data, 32'h0200_0003);
    xact(0, 12'h006, 2, 0); chk(r_data == 32'h0210, "R3 status", r_data, 32'h0210);
    xact(0, 12'h00E, 1, 0); chk(r_data == 32'h0, "R3 header type", r_data, 0);
    xact(0, 12'h02C, 4, 0); chk(r_data == 32'h0042_5A11, "R3 subsystem", r_data, 32'h0042_5A11);
    xact(0, 12'h03D, 4, 0); chk(r_data == 32'h0004_0201, "R3 tail bytes", r_data, 32'h0004_0201);
    xact(0, 12'h010, 4, 0); chk(r_data == 32'h0, "R7 bar0 mem type", r_data, 0);
    xact(0, 12'h014, 4, 0); chk(r_data == 32'h1, "R7 bar1 io type", r_data, 1);
    // R1 size sweep
    for (int s = 0; s < 8; s++) begin
      logic legal;
      legal = (s == 1 || s == 2 || s == 4);
      xact(0, 12'h000, 3'(s), 0);
      chk(r_err == !legal, "R1 size", {31'd0, r_err}, {31'd0, !legal});
      if (!legal) chk(r_data == 0, "R13 err data", r_data, 0);
    end
    // R2 device-specific region, upper address bits ignored
    xact(0, 12'h140, 1, 0); chk(r_err, "R2 offset 0x40", {31'd0, r_err}, 1);
    xact(1, 12'h1FC, 4, 32'h1); chk(r_err, "R2 offset 0xFC", {31'd0, r_err}, 1);
    xact(0, 12'h500, 2, 0); chk(!r_err && r_data == 32'hA5C3, "R2 high addr bits", r_data, 32'hA5C3);
    // R4 / R5 write classification sweeps
    for (int o = 0; o < 64; o++) begin
      logic ok;
      ok = (o == 8'h3C || o == 8'h0C || o == 8'h0D || (o >= 8 && o <= 11) || (o >= 8'h3D));
      xact(1, 12'(o), 1, 32'h5A ^ 32'(o));
      chk(r_err == !ok, "R4 one-byte write class", {31'd0, r_err}, {31'd0, !ok});
    end
    for (int o = 0; o < 64; o++) begin
      logic ok;
      ok = (o == 4 || o == 6 || o == 8'h0C);
      xact(1, 12'(o), 2, 32'h0000_1200);
      chk(r_err == !ok, "R5 two-byte write class", {31'd0, r_err}, {31'd0, !ok});
    end
    xact(0, 12'h008, 4, 0); chk(r_data == 32'h0200_0003, "R4 read-only untouched", r_data, 32'h0200_0003);
    xact(0, 12'h03C, 4, 0);
    chk(r_data == 32'h0402_0166, "R4 int line stored, pin kept", r_data, 32'h0402_0166);
    // R6 no spill
    xact(1, 12'h00D, 1, 32'h77);
    xact(1, 12'h00C, 2, 32'hBEEF);
    xact(0, 12'h00C, 2, 0); chk(r_data == 32'h77EF, "R6 cls no spill", r_data, 32'h77EF);
    xact(1, 12'h004, 2, 32'h0006);
    xact(0, 12'h004, 4, 0); chk(r_data == 32'h1200_0006, "R5 command stored", r_data, 32'h1200_0006);
    // R12
    xact(1, 12'h004, 4, 32'hFFFF_0107);
    chk(!r_err, "R12 cmd32 ok", {31'd0, r_err}, 0);
    xact(0, 12'h004, 4, 0); chk(r_data == 32'h1200_0107, "R12 status kept", r_data, 32'h1200_0107);
    xact(1, 12'h000, 4, 32'hDEAD_BEEF); chk(!r_err, "R12 ignored no err", {31'd0, r_err}, 0);
    xact(0, 12'h000, 4, 0); chk(r_data == 32'h0B17_A5C3, "R12 ignored write", r_data, 32'h0B17_A5C3);
    // R11
    xact(1, 12'h030, 4, 32'hFFFF_FFFE);
    xact(0, 12'h030, 4, 0); chk(r_data == 32'hFFFF_FFFF, "R11 rom allones", r_data, 32'hFFFF_FFFF);
    xact(1, 12'h030, 4, 32'h1234_5671);
    xact(0, 12'h030, 4, 0); chk(r_data == 32'h1234_5671, "R11 rom store", r_data, 32'h1234_5671);
    // R7..R10 BAR sweep
    for (int b = 0; b < 6; b++) begin
      logic [11:0] a;
      logic [31:0] m, addr, base;
      a = 12'h010 + 12'(4*b);
      m = tmask(b);
      xact(1, a, 4, 32'hFFFF_FFFF);
      chk(!r_rc, "R8 sizing no pulse", {31'd0, r_rc}, 0);
      xact(0, a, 4, 0);
      e = (~(SZ[b] - 1) & ~m) | (IOB[b] ? 32'h1 : 32'h0);
      chk(r_data == e, "R8 sizing value", r_data, e);
      chk(bar_en[b] == 1'b0, "R10 unprogrammed", {31'd0, bar_en[b]}, 0);
      xact(1, a, 2'd0 + 4, 32'h2); // only type bits: zero address
      chk(!r_rc && bar_base[32*b +: 32] == 0, "R9 zero addr no publish", {31'd0, r_rc}, 0);
      addr = 32'h0012_3000 + 32'(b) * 32'h0001_0000 + 32'hE;
      xact(1, a, 4, addr);
      chk(r_rc, "R9 change pulse", {31'd0, r_rc}, 1);
      base = (addr & ~m) + (IOB[b] ? IOW : MEMW);
      chk(bar_base[32*b +: 32] == base, "R9 decoded base", bar_base[32*b +: 32], base);
      chk(bar_en[b], "R10 enabled", {31'd0, bar_en[b]}, 1);
      xact(0, a, 4, 0);
      e = (addr & ~m) | (IOB[b] ? 32'h1 : 32'h0);
      chk(r_data == e, "R7 type bits kept", r_data, e);
      xact(1, a, 4, 32'hFFFF_FFFF);
      chk(bar_base[32*b +: 32] == base && !r_rc, "R8 resize keeps base", bar_base[32*b +: 32], base);
    end
    chk(!range_change, "R9 pulse ends", {31'd0, range_change}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule